// File: doc/BRIEF.md
# Attribute Table Entry Responder

This block answers table-read requests that software posts through a dword-oriented write mailbox. Each accepted request names one entry of a device attribute table by handle. The block streams a response into the read mailbox: a three-dword header, then the payload of that entry. The header carries the handle of the following entry, so software can walk the whole table one request at a time until it sees the all-ones terminator.

The table is not stored. It is computed from static region configuration. There is one optional volatile region and one optional persistent region, each with an enable and a byte size. Every present region contributes a fixed group of six entries. A request that is too short, or that names a handle past the end of the table, is dropped and flagged with a discard pulse. A read-mailbox length counter tracks how many response dwords have been written since the last request began.

Top module: `tbl_entry_responder`

## Requirements
- R1: After reset, `rsp_valid_o`, `rsp_last_o` and `discard_o` are 0 and `mbox_len_o` is 0.
- R2: Each present region owns six consecutive handles. The volatile region comes first when enabled. Within a group, offset 0 is a range entry (payload dword 0 type byte [7:0] = 0), offsets 1 to 4 are performance entries (type 1), and offset 5 is a memory-type entry (type 2). Payload dword 0 bits [31:16] hold the entry length in bytes: 24, 18 and 24 respectively.
- R3: The region index in payload dword 1 bits [7:0] is 0 for the first present region and 1 for the second. The range entry carries its base in payload dwords 2 and 3 (low, high) and its size in dwords 4 and 5. The volatile base is 0. The persistent base equals the volatile size when the volatile region is enabled, and 0 otherwise.
- R4: For the performance entries at offsets 1 to 4, payload dword 1 bits [23:16] hold the data kind (0 to 3). Payload dwords 2 and 3 hold the base unit, which is 10000 for kinds 0 and 1 and 1000 for kinds 2 and 3. Payload dword 4 bits [15:0] hold the value, which is 15, 25, 16 and 16 in kind order.
- R5: The range entry's non-volatile flag (payload dword 1 bit 8) is 1 only for the persistent region. The memory-type entry's attribute (payload dword 1 bits [15:8]) is 2 for the persistent region and 1 for the volatile region. Its offset dwords 2 and 3 are 0, and its length dwords 4 and 5 equal the region size.
- R6: A request whose `req_len_i` is below 3 dwords is dropped. `discard_o` pulses one cycle after the request, and no response dword is produced.
- R7: Response dword 2 bits [31:16] hold the next handle. This is the requested handle plus one, or 16'hFFFF for the last table entry. Bits [15:0] are 0.
- R8: Response dword 0 is {8'h00, 8'h02, 16'h1E98}. Response dword 1 is the response length in dwords, equal to ceil((12 + entry bytes) / 4), which is 9, 8 or 9. The entry payload starts at response dword 3.
- R9: `mbox_len_o` is cleared to 0 when a request is taken in, and increases by one for each response dword streamed. It ends equal to the response length.
- R10: A request whose handle is at or beyond the table entry count is dropped with a `discard_o` pulse.
- R11: With both regions disabled the table is empty, and every request is dropped.
- R12: Response dwords stream on consecutive cycles starting one cycle after the request, with `rsp_idx_o` counting from 0. `rsp_last_o` marks the dword whose index is `rsp_len_o - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vol_en_i | input | 1 | Volatile region present |
| pers_en_i | input | 1 | Persistent region present |
| vol_size_i | input | AW | Volatile region size in bytes |
| pers_size_i | input | AW | Persistent region size in bytes |
| req_valid_i | input | 1 | Request strobe, taken in when idle |
| req_len_i | input | LW | Request object length in dwords |
| req_handle_i | input | 16 | Requested entry handle |
| rsp_valid_o | output | 1 | Response dword valid |
| rsp_idx_o | output | LW | Dword index within the response |
| rsp_data_o | output | 32 | Response dword |
| rsp_len_o | output | LW | Response length in dwords |
| rsp_last_o | output | 1 | Final dword of the response |
| discard_o | output | 1 | Request dropped (one-cycle pulse) |
| mbox_len_o | output | LW | Read-mailbox dwords written since the last request |

## Verification
The bench targets the last-entry terminator in each region layout. A design that chains past the end would show handle+1 instead of 16'hFFFF. It also covers the persistent base with the volatile region present and absent; a design that ignores the volatile enable would report a stale volatile size as the base. The 18-byte performance entries check the dword rounding, since truncating would give a length of 7 instead of 8. Short requests, out-of-range handles and the empty table must each give a discard pulse with no response dword and a cleared mailbox count. A design that skips the count clear would leave the previous length in place.

// File: rtl/tbl_rsp_pkg.sv
package tbl_rsp_pkg;
  localparam int unsigned HW         = 16;
  localparam int unsigned PER_REGION = 6;
  localparam int unsigned REQ_MIN_DW = 3;
  localparam logic [15:0] VENDOR_ID  = 16'h1E98;
  localparam logic [7:0]  OBJ_TYPE   = 8'h02;
  localparam logic [15:0] HDR_BYTES  = 16'd12;

  typedef enum logic [1:0] {
    KIND_RANGE = 2'd0,
    KIND_PERF  = 2'd1,
    KIND_MTYPE = 2'd2
  } kind_e;

  function automatic logic [15:0] entry_bytes(kind_e k);
    return (k == KIND_PERF) ? 16'd18 : 16'd24;
  endfunction

  function automatic logic [31:0] perf_unit(logic [1:0] sub);
    return sub[1] ? 32'd1000 : 32'd10000;
  endfunction

  function automatic logic [15:0] perf_value(logic [1:0] sub);
    case (sub)
      2'd0:    return 16'd15;
      2'd1:    return 16'd25;
      default: return 16'd16;
    endcase
  endfunction
endpackage

// File: rtl/tbl_handle_map.sv
module tbl_handle_map
  import tbl_rsp_pkg::*;
(
  input  logic          vol_en_i,
  input  logic          pers_en_i,
  input  logic [HW-1:0] handle_i,
  output logic          hit_o,
  output logic          last_o,
  output kind_e         kind_o,
  output logic [1:0]    sub_o,
  output logic          second_o,
  output logic          pers_o
);
  logic [1:0]    n_reg;
  logic [HW-1:0] n_ent, off;

  always_comb begin
    n_reg    = {1'b0, vol_en_i} + {1'b0, pers_en_i};
    n_ent    = HW'(n_reg) * HW'(PER_REGION);
    hit_o    = handle_i < n_ent;
    last_o   = hit_o && (handle_i == n_ent - HW'(1));
    second_o = handle_i >= HW'(PER_REGION);
    off      = second_o ? handle_i - HW'(PER_REGION) : handle_i;
    pers_o   = second_o || !vol_en_i;
    sub_o    = 2'(off - HW'(1));
    if (off == '0)                     kind_o = KIND_RANGE;
    else if (off == HW'(PER_REGION-1)) kind_o = KIND_MTYPE;
    else                               kind_o = KIND_PERF;
  end
endmodule

// File: rtl/tbl_entry_gen.sv
module tbl_entry_gen
  import tbl_rsp_pkg::*;
#(
  parameter int unsigned AW = 64,
  parameter int unsigned LW = 18
) (
  input  logic          vol_en_i,
  input  logic [AW-1:0] vol_size_i,
  input  logic [AW-1:0] pers_size_i,
  input  logic [HW-1:0] handle_i,
  input  logic          last_i,
  input  kind_e         kind_i,
  input  logic [1:0]    sub_i,
  input  logic          second_i,
  input  logic          pers_i,
  input  logic [LW-1:0] word_i,
  output logic [LW-1:0] rsp_len_o,
  output logic [31:0]   data_o
);
  logic [63:0]   base, size;
  logic [15:0]   ebytes, total;
  logic [HW-1:0] next;
  logic [7:0]    rgn;
  logic [2:0]    pw;
  logic [31:0]   pay;

  always_comb begin
    size      = pers_i ? 64'(pers_size_i) : 64'(vol_size_i);
    base      = (pers_i && vol_en_i) ? 64'(vol_size_i) : 64'd0;
    ebytes    = entry_bytes(kind_i);
    total     = HDR_BYTES + ebytes + 16'd3;
    rsp_len_o = LW'(total >> 2);
    next      = last_i ? '1 : handle_i + HW'(1);
    rgn       = {7'd0, second_i};
    pw        = 3'(word_i - LW'(3));
    pay       = '0;
    if (pw == 3'd0) begin
      pay = {ebytes, 8'h00, 6'd0, kind_i};
    end else begin
      case (kind_i)
        KIND_RANGE:
          case (pw)
            3'd1: pay = {23'd0, pers_i, rgn};
            3'd2: pay = base[31:0];
            3'd3: pay = base[63:32];
            3'd4: pay = size[31:0];
            3'd5: pay = size[63:32];
            default: pay = '0;
          endcase
        KIND_PERF:
          case (pw)
            3'd1: pay = {8'h00, 6'd0, sub_i, 8'h00, rgn};
            3'd2: pay = perf_unit(sub_i);
            3'd4: pay = {16'h0000, perf_value(sub_i)};
            default: pay = '0;
          endcase
        default:
          case (pw)
            3'd1: pay = {16'h0000, pers_i ? 8'd2 : 8'd1, rgn};
            3'd4: pay = size[31:0];
            3'd5: pay = size[63:32];
            default: pay = '0;
          endcase
      endcase
    end
    if (word_i == LW'(0))      data_o = {8'h00, OBJ_TYPE, VENDOR_ID};
    else if (word_i == LW'(1)) data_o = 32'(rsp_len_o);
    else if (word_i == LW'(2)) data_o = {next, 16'h0000};
    else                       data_o = pay;
  end
endmodule

// File: rtl/tbl_rsp_seq.sv
module tbl_rsp_seq
  import tbl_rsp_pkg::*;
#(
  parameter int unsigned LW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [LW-1:0] req_len_i,
  input  logic [HW-1:0] req_handle_i,
  input  logic          hit_i,
  input  logic [LW-1:0] cur_len_i,
  output logic [HW-1:0] cur_handle_o,
  output logic          rsp_valid_o,
  output logic [LW-1:0] rsp_idx_o,
  output logic [LW-1:0] rsp_len_o,
  output logic          rsp_last_o,
  output logic          discard_o,
  output logic [LW-1:0] mbox_len_o
);
  logic          busy_q, disc_q, accept, ok;
  logic [HW-1:0] hdl_q;
  logic [LW-1:0] idx_q, len_q, cnt_q;

  assign accept       = req_valid_i && !busy_q;
  assign ok           = accept && hit_i && (req_len_i >= LW'(REQ_MIN_DW));
  assign cur_handle_o = busy_q ? hdl_q : req_handle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      disc_q <= 1'b0;
      hdl_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      disc_q <= accept && !ok;
      if (accept) cnt_q <= '0;
      if (ok) begin
        busy_q <= 1'b1;
        hdl_q  <= req_handle_i;
        idx_q  <= '0;
        len_q  <= cur_len_i;
      end
      if (busy_q) begin
        cnt_q <= cnt_q + LW'(1);
        idx_q <= idx_q + LW'(1);
        if (idx_q == len_q - LW'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign rsp_valid_o = busy_q;
  assign rsp_idx_o   = idx_q;
  assign rsp_len_o   = len_q;
  assign rsp_last_o  = busy_q && (idx_q == len_q - LW'(1));
  assign discard_o   = disc_q;
  assign mbox_len_o  = cnt_q;
endmodule

// File: rtl/tbl_entry_responder.sv
module tbl_entry_responder
  import tbl_rsp_pkg::*;
#(
  parameter int unsigned AW = 64,
  parameter int unsigned LW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vol_en_i,
  input  logic          pers_en_i,
  input  logic [AW-1:0] vol_size_i,
  input  logic [AW-1:0] pers_size_i,
  input  logic          req_valid_i,
  input  logic [LW-1:0] req_len_i,
  input  logic [15:0]   req_handle_i,
  output logic          rsp_valid_o,
  output logic [LW-1:0] rsp_idx_o,
  output logic [31:0]   rsp_data_o,
  output logic [LW-1:0] rsp_len_o,
  output logic          rsp_last_o,
  output logic          discard_o,
  output logic [LW-1:0] mbox_len_o
);
  logic [HW-1:0] cur_handle;
  logic          hit, last, second, pers;
  kind_e         kind;
  logic [1:0]    sub;
  logic [LW-1:0] cur_len;

  tbl_handle_map u_map (
    .vol_en_i, .pers_en_i, .handle_i(cur_handle),
    .hit_o(hit), .last_o(last), .kind_o(kind), .sub_o(sub),
    .second_o(second), .pers_o(pers)
  );

  tbl_entry_gen #(.AW(AW), .LW(LW)) u_gen (
    .vol_en_i, .vol_size_i, .pers_size_i, .handle_i(cur_handle),
    .last_i(last), .kind_i(kind), .sub_i(sub), .second_i(second),
    .pers_i(pers), .word_i(rsp_idx_o), .rsp_len_o(cur_len),
    .data_o(rsp_data_o)
  );

  tbl_rsp_seq #(.LW(LW)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_len_i, .req_handle_i,
    .hit_i(hit), .cur_len_i(cur_len), .cur_handle_o(cur_handle),
    .rsp_valid_o, .rsp_idx_o, .rsp_len_o, .rsp_last_o,
    .discard_o, .mbox_len_o
  );
endmodule

// File: rtl/tbl_rsp_checker.sv
module tbl_rsp_checker #(
  parameter int unsigned AW = 64,
  parameter int unsigned LW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vol_en_i,
  input logic          pers_en_i,
  input logic [AW-1:0] vol_size_i,
  input logic [AW-1:0] pers_size_i,
  input logic          req_valid_i,
  input logic [LW-1:0] req_len_i,
  input logic [15:0]   req_handle_i,
  input logic          rsp_valid_o,
  input logic [LW-1:0] rsp_idx_o,
  input logic [31:0]   rsp_data_o,
  input logic [LW-1:0] rsp_len_o,
  input logic          rsp_last_o,
  input logic          discard_o,
  input logic [LW-1:0] mbox_len_o
);
  AST_DISCARD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> !rsp_valid_o); // R6
  AST_SHORT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rsp_valid_o && req_len_i < LW'(3)) |=> discard_o); // R6
  AST_EMPTY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rsp_valid_o && !vol_en_i && !pers_en_i) |=> discard_o); // R11
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rsp_valid_o) |=> mbox_len_o == '0); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> mbox_len_o == $past(mbox_len_o) + LW'(1)); // R9
  AST_IDX_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_idx_o == mbox_len_o); // R12
  AST_LAST_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> (rsp_valid_o && rsp_idx_o == rsp_len_o - LW'(1))); // R12
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_len_o == LW'(8) || rsp_len_o == LW'(9))); // R8
endmodule

bind tbl_entry_responder tbl_rsp_checker #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/tbl_entry_responder_bench.sv
`timescale 1ns/1ps
module tbl_entry_responder_bench;
  localparam int LW = 18;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ve = 1'b0, pe = 1'b0;
  logic [63:0] vs = '0, ps = '0;
  logic req_v = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic [15:0] req_h = '0;
  logic rsp_v, rsp_last, disc;
  logic [LW-1:0] rsp_idx, rsp_len, mbox;
  logic [31:0] rsp_d;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tbl_entry_responder u_tbl_entry_responder (
    .clk_i(clk), .rst_ni(rst_n), .vol_en_i(ve), .pers_en_i(pe),
    .vol_size_i(vs), .pers_size_i(ps), .req_valid_i(req_v),
    .req_len_i(req_len), .req_handle_i(req_h), .rsp_valid_o(rsp_v),
    .rsp_idx_o(rsp_idx), .rsp_data_o(rsp_d), .rsp_len_o(rsp_len),
    .rsp_last_o(rsp_last), .discard_o(disc), .mbox_len_o(mbox)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_ent();
    return 6 * (int'(ve) + int'(pe));
  endfunction

  function automatic int ebytes(int h);
    int off = h % 6;
    return (off == 0 || off == 5) ? 24 : 18;
  endfunction

  function automatic int exp_len(int h);
    return (12 + ebytes(h) + 3) / 4;
  endfunction

  function automatic logic [31:0] exp_word(int h, int w);
    int r = h / 6, off = h % 6;
    bit p = (r == 1) || !ve;
    logic [63:0] sz = p ? ps : vs;
    logic [63:0] bs = (p && ve) ? vs : 64'd0;
    logic [7:0] ty = (off == 0) ? 8'd0 : (off == 5) ? 8'd2 : 8'd1;
    int vals[4] = '{15, 25, 16, 16};
    case (w)
      0: return 32'h0002_1E98;
      1: return 32'(exp_len(h));
      2: return {(h == n_ent() - 1) ? 16'hFFFF : 16'(h + 1), 16'h0};
      3: return {16'(ebytes(h)), 8'h0, ty};
      default: ;
    endcase
    if (off == 0) begin
      case (w)
        4: return {23'd0, p, 8'(r)};
        5: return bs[31:0];
        6: return bs[63:32];
        7: return sz[31:0];
        8: return sz[63:32];
        default: return 32'd0;
      endcase
    end else if (off == 5) begin
      case (w)
        4: return {16'd0, p ? 8'd2 : 8'd1, 8'(r)};
        7: return sz[31:0];
        8: return sz[63:32];
        default: return 32'd0;
      endcase
    end else begin
      case (w)
        4: return {8'd0, 8'(off - 1), 8'd0, 8'(r)};
        5: return (off <= 2) ? 32'd10000 : 32'd1000;
        7: return 32'(vals[off-1]);
        default: return 32'd0;
      endcase
    end
  endfunction

  function automatic string tag_of(int h, int w);
    int off = h % 6;
    if (w < 2) return "R8";
    if (w == 2) return "R7";
    if (w == 3) return "R2";
    if (off == 0) return (w == 4) ? "R5_R3" : "R3";
    if (off == 5) return "R5";
    return "R4";
  endfunction

  task automatic send(int len, int h);
    @(negedge clk);
    req_v = 1'b1; req_len = LW'(len); req_h = 16'(h);
    @(negedge clk);
    req_v = 1'b0;
  endtask

  task automatic expect_drop(int len, int h, string req);
    send(len, h);
    chk(disc === 1'b1, req, disc, 1);
    chk(rsp_v === 1'b0, req, rsp_v, 0);
    chk(mbox === '0, "R9", mbox, 0);
    @(negedge clk);
    chk(disc === 1'b0 && rsp_v === 1'b0, req, {disc, rsp_v}, 0);
  endtask

  task automatic expect_rsp(int h);
    int n = 0;
    logic [31:0] got [16];
    send(3 + int'($urandom_range(0, 2)), h);
    chk(disc === 1'b0, "R12", disc, 0);
    while (rsp_v === 1'b1 && n < 16) begin
      if (rsp_idx !== LW'(n)) chk(0, "R12", rsp_idx, n);
      if (rsp_last !== (n == exp_len(h) - 1)) chk(0, "R12", rsp_last, n == exp_len(h) - 1);
      got[n] = rsp_d;
      n++;
      @(negedge clk);
    end
    chk(n == exp_len(h), "R8", n, exp_len(h));
    chk(mbox == LW'(exp_len(h)), "R9", mbox, exp_len(h));
    for (int w = 0; w < n && w < exp_len(h); w++)
      chk(got[w] === exp_word(h, w), tag_of(h, w), got[w], exp_word(h, w));
  endtask

  task automatic run_cfg(bit v, bit p);
    @(negedge clk);
    ve = v; pe = p;
    vs = {32'($urandom_range(0, 15)), $urandom & 32'hF000_0000};
    ps = {32'($urandom_range(0, 15)), $urandom & 32'hF000_0000};
    for (int h = 0; h < n_ent(); h++) expect_rsp(h);
    for (int i = 0; i < 10 && n_ent() > 0; i++) expect_rsp(int'($urandom_range(0, n_ent() - 1)));
    expect_drop(3, n_ent(), n_ent() == 0 ? "R11" : "R10");
    expect_drop(3, 16'hFFFF, n_ent() == 0 ? "R11" : "R10");
    if (n_ent() > 0) begin
      expect_rsp(n_ent() - 1);
      expect_drop(2, 0, "R6");
      expect_rsp(0);
      expect_drop(0, n_ent() - 1, "R6");
    end
  endtask

  initial begin
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    chk(rsp_v === 1'b0 && rsp_last === 1'b0, "R1", {rsp_v, rsp_last}, 0);
    chk(disc === 1'b0 && mbox === '0, "R1", {disc, mbox}, 0);
    rst_n = 1'b1;
    run_cfg(1'b1, 1'b1);
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) chk(0, "R12", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule